// File: doc/BRIEF.md
# Daisy-Chainable Serial Result Shifter

This block is the output side of a serial converter. When a conversion finishes, the engine raises a one-cycle completion strobe together with the parallel result. The shifter captures that word and, on an externally supplied data clock, sends it out one bit per rising edge. The clock may be continuous or may run in bursts. The word is preceded by a single-clock frame marker, and the most significant bit goes first.

Once the last result bit has gone out, the serial line keeps going. It repeats the chain input, delayed by exactly one word length, starting from the value seen on the first bit edge. Several devices can therefore be wired in a daisy chain: each device's data output drives the chain input of the next one, and a single reader collects all the words back to back on one line. Every output changes only on a rising edge of the data clock. A reader can sample on the falling edge of the same pulse or on the next rising edge.

Top module: `rs_serial_shifter`

## Requirements
- R1: A rising edge that samples `done_i` high (edge #0) captures `result_i` and raises `sync_o` for the clock period that follows.
- R2: `sync_o` is low after every rising edge at which `done_i` was low.
- R3: In the marker period after edge #0, `data_o` is low.
- R4: After the k-th rising edge following edge #0 (k = 1 to WIDTH), `data_o` equals result bit WIDTH-k, so bit WIDTH-1 is first and bit 0 is last.
- R5: After edge WIDTH+1+j (j ≥ 0), `data_o` equals the `tag_i` value sampled at edge 1+j. This holds for as long as the clock runs.
- R6: A new `done_i` during an unfinished readout discards the old word and any chain bits already taken in. It then restarts the frame from R1 with the new result.
- R7: From reset until the first `done_i`, `sync_o` and `data_o` stay low, and `tag_i` has no effect on `data_o`.
- R8: `rst_ni` low asynchronously forces `sync_o` and `data_o` low and returns the block to the state of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Externally supplied data clock, rising-edge active, may be gated |
| rst_ni | input | 1 | Asynchronous reset, active low |
| done_i | input | 1 | Conversion-complete strobe, sampled on the rising edge |
| result_i | input | WIDTH | Parallel conversion result, valid while `done_i` is high |
| tag_i | input | 1 | Chain input from the upstream device's data output |
| sync_o | output | 1 | Frame marker, high for one clock before the first data bit |
| data_o | output | 1 | Serial output: result bits MSB first, then the delayed chain input |

## Verification
The bench builds the block with the default WIDTH of 16, which gives the full 17-edge frame: one marker edge and sixteen result bits. After that it runs the chain stream for several more edges, so the 16-clock chain delay is checked at its true length. It also checks that bits shifted in before a reload are lost. With this width, a reload after only a few bits or after the chain stream has started is easy to set up. A reset in the middle of a frame and chain activity before the first conversion are tested as well.

// File: rtl/rs_pkg.sv
package rs_pkg;

    // Readout phase of the shifter.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,   // no word captured since reset
        PH_MARK   = 2'd1,   // marker period right after a capture
        PH_STREAM = 2'd2    // result bits followed by the chain stream
    } rs_phase_e;

endpackage

// File: rtl/rs_sequencer.sv
module rs_sequencer
    import rs_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic done_i,
    output logic armed_o,
    output logic sync_o
);

    typedef struct packed {
        rs_phase_e phase;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (done_i) begin
            st_d.phase = PH_MARK;
        end else begin
            unique case (st_q.phase)
                PH_IDLE:   st_d.phase = PH_IDLE;
                PH_MARK:   st_d.phase = PH_STREAM;
                PH_STREAM: st_d.phase = PH_STREAM;
                default:   st_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.phase <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign armed_o = (st_q.phase != PH_IDLE);
    assign sync_o  = (st_q.phase == PH_MARK);

endmodule

// File: rtl/rs_shift_core.sv
module rs_shift_core #(
    parameter int WIDTH = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic             shift_i,
    input  logic [WIDTH-1:0] par_i,
    input  logic             ser_i,
    output logic             msb_o
);

    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] sreg;
    } core_state_t;

    core_state_t st_d, st_q;

    // A load wins over a shift, so a new capture always restarts the word.
    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.sreg = par_i;
        end else if (shift_i) begin
            st_d.sreg = {st_q.sreg[MSB-1:0], ser_i};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.sreg <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign msb_o = st_q.sreg[MSB];

endmodule

// File: rtl/rs_serial_shifter.sv
module rs_serial_shifter #(
    parameter int WIDTH = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             done_i,
    input  logic [WIDTH-1:0] result_i,
    input  logic             tag_i,
    output logic             sync_o,
    output logic             data_o
);

    logic armed;
    logic core_msb;

    rs_sequencer u_seq (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .done_i  (done_i),
        .armed_o (armed),
        .sync_o  (sync_o)
    );

    rs_shift_core #(
        .WIDTH (WIDTH)
    ) u_core (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (done_i),
        .shift_i (armed),
        .par_i   (result_i),
        .ser_i   (tag_i),
        .msb_o   (core_msb)
    );

    // Output stage: retiming the MSB by one edge puts bit WIDTH-1 on the line
    // at edge #1, while the register shifts in the chain bit at that same edge.
    typedef struct packed {
        logic data;
    } out_state_t;

    out_state_t out_d, out_q;

    always_comb begin
        out_d = out_q;
        if (done_i) begin
            out_d.data = 1'b0;
        end else if (armed) begin
            out_d.data = core_msb;
        end else begin
            out_d.data = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            out_q.data <= 1'b0;
        end else begin
            out_q <= out_d;
        end
    end

    assign data_o = out_q.data;

endmodule

// File: rtl/rs_shifter_checker.sv
module rs_shifter_checker #(
    parameter int WIDTH = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             done_i,
    input logic [WIDTH-1:0] result_i,
    input logic             tag_i,
    input logic             sync_o,
    input logic             data_o
);

    localparam int CW = $clog2(WIDTH + 2) + 1;
    localparam logic [CW-1:0] CNT_SAT = CW'(WIDTH + 1);

    // Reference bookkeeping kept by the checker itself.
    logic             armed_q;
    logic [CW-1:0]    cnt_q;
    logic [WIDTH-1:0] word_q;
    logic [WIDTH:0]   hist_q;
    logic             exp_bit;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
            word_q  <= '0;
            hist_q  <= '0;
        end else begin
            hist_q <= {hist_q[WIDTH-1:0], tag_i};
            if (done_i) begin
                armed_q <= 1'b1;
                cnt_q   <= '0;
                word_q  <= result_i;
            end else if (armed_q && cnt_q != CNT_SAT) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        exp_bit = 1'b0;
        for (int i = 0; i < WIDTH; i++) begin
            if (int'(cnt_q) == WIDTH - i) exp_bit = word_q[i];
        end
    end

    // R1: the capture edge is followed by the marker
    a_r1_marker_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |=> sync_o);

    // R2: no marker without a capture on the previous edge
    a_r2_marker_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_i |=> !sync_o);

    // R3: line is low during the marker period
    a_r3_data_low_in_mark: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_q && cnt_q == '0) |-> !data_o);

    // R4, R6: result bits MSB first, counted from the latest capture
    a_r4_result_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_q && cnt_q != '0 && int'(cnt_q) <= WIDTH) |-> (data_o == exp_bit));

    // R5: chain input delayed by one word length
    a_r5_chain_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_q && cnt_q == CNT_SAT) |-> (data_o == hist_q[WIDTH]));

    // R7: quiet until the first capture
    a_r7_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !armed_q |-> (!data_o && !sync_o));

endmodule

bind rs_serial_shifter rs_shifter_checker #(
    .WIDTH (WIDTH)
) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .done_i   (done_i),
    .result_i (result_i),
    .tag_i    (tag_i),
    .sync_o   (sync_o),
    .data_o   (data_o)
);

// File: tb/sim_rs_serial_shifter.sv
module sim_rs_serial_shifter;

    localparam int W          = 16;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         done = 1'b0;
    logic [W-1:0] result = '0;
    logic         tag = 1'b0;
    logic         sync_w;
    logic         data_w;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rs_serial_shifter #(.WIDTH(W)) u0 (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .done_i   (done),
        .result_i (result),
        .tag_i    (tag),
        .sync_o   (sync_w),
        .data_o   (data_w)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
        end
    endtask

    // One rising edge, then return at the following falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic tag_pat(input int mode, input int k);
        return logic'(((k * mode) + (k / 3)) % 2);
    endfunction

    // Starts a frame at the current falling edge and checks nedges edges after #0.
    task automatic run_frame(input logic [W-1:0] word, input int mode, input int nedges);
        logic tags [0:63];
        for (int k = 0; k < 64; k++) tags[k] = tag_pat(mode, k);
        done   = 1'b1;
        result = word;
        tag    = ~tags[1];
        step();                                   // edge #0
        check("R1 marker high", sync_w, 1'b1);
        check("R3 data low in marker", data_w, 1'b0);
        done   = 1'b0;
        result = ~word;
        tag    = tags[1];
        for (int k = 1; k <= nedges; k++) begin
            step();                               // edge k samples tags[k]
            check("R2 marker low", sync_w, 1'b0);
            if (k <= W) check("R4 result bit", data_w, word[W-k]);
            else        check("R5 chain bit", data_w, tags[k-W]);
            tag = tags[k+1];
        end
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        done  = 1'b0;
        tag   = 1'b0;
        #(CLK_PERIOD / 4);
        check("R8 sync low in reset", sync_w, 1'b0);
        check("R8 data low in reset", data_w, 1'b0);
        step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_idle();
        for (int k = 0; k < 24; k++) begin
            tag = logic'(k % 2);
            step();
            check("R7 idle data low", data_w, 1'b0);
            check("R7 idle sync low", sync_w, 1'b0);
        end
    endtask

    task automatic t_frames();
        run_frame(16'hA5C3, 1, W + 6);
        run_frame(16'h0001, 3, W + 4);
        run_frame(16'h8000, 2, W + 4);
        run_frame(16'hFFFF, 1, W + 2);
    endtask

    task automatic t_reload();
        run_frame(16'h3C5A, 1, 5);                // cut short after 5 bits
        run_frame(16'hD00B, 3, W + 5);            // R6 restart
        run_frame(16'h1234, 2, W + 3);            // R6 reload while chain streams
        run_frame(16'h9ABC, 1, W + 3);
    endtask

    task automatic t_mid_reset();
        run_frame(16'hFFFF, 1, 3);
        #(CLK_PERIOD / 4);
        rst_n = 1'b0;
        #(CLK_PERIOD / 8);
        check("R8 async clear data", data_w, 1'b0);
        check("R8 async clear sync", sync_w, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 20; k++) begin
            tag = 1'b1;
            step();
            check("R8 idle after reset data", data_w, 1'b0);
            check("R8 idle after reset sync", sync_w, 1'b0);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        @(negedge clk);
        apply_reset();
        t_idle();
        t_frames();
        t_reload();
        t_mid_reset();
        run_frame(16'h5AA5, 3, W + 3);
        finish_run();
    end

endmodule